// File: doc/BRIEF.md
# Serial Character Transmitter with Per-Bit Timing Trim

This block serialises one character at a time onto an idle-high serial line. A byte arrives through a valid/ready handshake. The block captures the byte together with the current frame settings, then sends a frame made of these parts, in order:

- a low start bit;
- 5 to 8 data bits, least significant bit first;
- an optional parity bit;
- one or two high stop bits.

A divisor input sets the nominal length of each bit. A trim word can make any single bit position of the frame one sixteenth of a bit longer or shorter. Spreading such trims over a frame lets the average bit rate hit fractions that the integer divisor cannot reach.

A break request holds the line low once any frame in progress has finished. The line goes high again when the request is withdrawn. A status output shows whether a frame is on the line.

Top module: `uart_trim_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress and no break is requested, `txd` is 1, `in_ready` is 1 and `tx_empty` is 1.
- R2: `in_ready` is 1 only when no frame is in progress and `brk_req` is 0. A byte is taken at the rising edge where `in_valid` and `in_ready` are both 1. From the next cycle on, `txd` is 0 (start bit), `tx_empty` is 0 and `in_ready` is 0 until the frame ends.
- R3: `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The data bits follow the start bit, least significant first.
- R4: `cfg_par` selects parity, placed right after the last data bit:
  - 0 to 3: no parity bit;
  - 4: odd parity (data plus parity has an odd number of ones);
  - 5: even parity;
  - 6: parity bit always 1;
  - 7: parity bit always 0.
- R5: `cfg_stop` = 0 ends the frame with one high stop bit, and `cfg_stop` = 1 ends it with two.
- R6: With trim code 0, a bit lasts exactly (`divisor`+1)*16 clock cycles.
- R7: Frame positions are numbered in sending order: start is position 0, then the data bits, then parity if present, then the stop bits. Position k uses `trim[2k+1:2k]`. The codes act as follows:
  - 1: the bit lasts (`divisor`+1)*17 cycles;
  - 3: the bit lasts (`divisor`+1)*15 cycles;
  - 0 and 2: the bit keeps the nominal length.
  Codes for positions beyond the frame's length have no effect.
- R8: The byte, `cfg_len`, `cfg_stop`, `cfg_par`, `divisor` and `trim` are captured when the byte is taken. Changing them during the frame does not change that frame.
- R9: While `brk_req` is 1, the frame in progress finishes unchanged. From the cycle after that frame's last bit ends (or from the cycle after `brk_req` rises, if the block is idle), `txd` is 0 and `in_ready` is 0. `txd` is 1 again in the cycle after `brk_req` falls.
- R10: `tx_empty` is 1 exactly when no frame is in progress, including while a break is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the bit-timing reference |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_ready | output | 1 | The transmitter will take the offered byte at this edge |
| in_data | input | 8 | Character to send; unused upper bits are ignored |
| cfg_len | input | 2 | Data-bit count code |
| cfg_stop | input | 1 | Stop-bit count select |
| cfg_par | input | 3 | Parity mode code |
| divisor | input | DIV_W | Bit-time divisor; prescaler period is divisor+1 cycles |
| trim | input | 24 | Two-bit trim code for each of 12 frame positions |
| brk_req | input | 1 | Hold the line low after the current frame |
| txd | output | 1 | Serial line, idle high |
| tx_empty | output | 1 | No frame is in progress |

## Verification
The hardest situation to reach is a frame where every bit has its own length. It combines long, short and neutral trim codes with a non-zero divisor and a short format, so that unused high trim fields are present and must be ignored. The stimulus draws full 24-bit trim words, divisors and formats at random, as well as the byte itself. It compares the line against a waveform computed cycle by cycle from the requirements, so a slot that is off by a single cycle shows up.

Settings are scrambled as soon as each byte is taken, which exposes any setting that is not captured at acceptance. A break raised in the middle of a frame, and one raised while the block is idle, are directed cases.

// File: rtl/uart_trim_pkg.sv
// Package: shared constants, types and frame-building helpers for the
// trimmed serial transmitter. Assumes at most 12 frame positions.
package uart_trim_pkg;

    localparam int FRAME_MAX  = 12;
    localparam int OVERSAMPLE = 16;
    localparam int TRIM_W     = 2 * FRAME_MAX;
    localparam int POS_W      = $clog2(FRAME_MAX + 1);
    localparam int SUB_W      = $clog2(OVERSAMPLE + 2);

    typedef enum logic [1:0] {
        TRIM_KEEP  = 2'd0,
        TRIM_LONG  = 2'd1,
        TRIM_NOP   = 2'd2,
        TRIM_SHORT = 2'd3
    } trim_code_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [POS_W-1:0]     len;
    } frame_t;

    // Assemble the frame bit vector (position 0 first) and its length.
    function automatic frame_t build_frame(input logic [7:0] d,
                                           input logic [1:0] len_code,
                                           input logic       stop2,
                                           input logic [2:0] par);
        frame_t     f;
        int         nd;
        int         idx;
        logic [7:0] mask;
        logic       p;
        f.bits    = '1;
        f.bits[0] = 1'b0;
        nd        = 5 + int'(len_code);
        mask      = 8'hFF >> (2'd3 - len_code);
        for (int i = 0; i < 8; i++) begin
            if (i < nd) f.bits[1 + i] = d[i];
        end
        idx = 1 + nd;
        if (par[2]) begin
            case (par[1:0])
                2'd0:    p = ~(^(d & mask));
                2'd1:    p = ^(d & mask);
                2'd2:    p = 1'b1;
                default: p = 1'b0;
            endcase
            f.bits[idx] = p;
            idx = idx + 1;
        end
        idx   = idx + (stop2 ? 2 : 1);
        f.len = POS_W'(idx);
        return f;
    endfunction

    // Number of prescaler ticks one bit slot lasts for a trim code.
    function automatic logic [SUB_W-1:0] slot_ticks(input logic [1:0] code);
        case (code)
            TRIM_LONG:  return SUB_W'(OVERSAMPLE + 1);
            TRIM_SHORT: return SUB_W'(OVERSAMPLE - 1);
            default:    return SUB_W'(OVERSAMPLE);
        endcase
    endfunction

endpackage

// File: rtl/uart_trim_framer.sv
// Framer: captures the byte and every setting at acceptance and holds the
// assembled frame, trim word and divisor stable for the whole frame.
// Assumes load is pulsed only while no frame is in progress.
module uart_trim_framer
    import uart_trim_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [7:0]           in_data,
    input  logic [1:0]           cfg_len,
    input  logic                 cfg_stop,
    input  logic [2:0]           cfg_par,
    input  logic [DIV_W-1:0]     divisor,
    input  logic [TRIM_W-1:0]    trim,
    output logic [FRAME_MAX-1:1] frame_bits,
    output logic [POS_W-1:0]     frame_len,
    output logic [TRIM_W-1:0]    trim_q,
    output logic [DIV_W-1:0]     div_q
);

    frame_t next_frame;

    // Combinational frame assembly from the live inputs.
    always_comb next_frame = build_frame(in_data, cfg_len, cfg_stop, cfg_par);

    // Capture registers, written only on an accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_bits <= '1;
            frame_len  <= POS_W'(FRAME_MAX);
            trim_q     <= '0;
            div_q      <= '0;
        end else if (load) begin
            frame_bits <= next_frame.bits[FRAME_MAX-1:1];
            frame_len  <= next_frame.len;
            trim_q     <= trim;
            div_q      <= divisor;
        end
    end

    a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (frame_len >= POS_W'(7)) && (frame_len <= POS_W'(FRAME_MAX)));

endmodule

// File: rtl/uart_trim_prescaler.sv
// Prescaler: while run is high, emits one tick every limit+1 cycles; held
// at zero while run is low so the first tick of a frame is a full period.
module uart_trim_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == limit);

    // Period counter, cleared when idle or on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (!run || tick)   cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= limit));

    a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/uart_trim_sequencer.sv
// Sequencer: owns the frame state, walks the bit positions, applies the
// per-position trim to the slot length, and drives the registered line,
// including break. Assumes frame inputs are stable while busy.
module uart_trim_sequencer
    import uart_trim_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 brk_req,
    input  logic                 tick,
    input  logic [FRAME_MAX-1:1] frame_bits,
    input  logic [POS_W-1:0]     frame_len,
    input  logic [TRIM_W-1:0]    trim_q,
    output logic                 in_ready,
    output logic                 load,
    output logic                 busy,
    output logic                 txd
);

    logic [POS_W-1:0] pos;
    logic [SUB_W-1:0] sub;
    logic [1:0]       cur_code;
    logic [SUB_W-1:0] ticks_n;
    logic             slot_end;
    logic             last_pos;

    assign in_ready = !busy && !brk_req;
    assign load     = in_valid && in_ready;

    // Trim code and slot length for the position on the line.
    always_comb begin
        cur_code = trim_q[{pos, 1'b0} +: 2];
        ticks_n  = slot_ticks(cur_code);
        slot_end = tick && (sub == ticks_n - SUB_W'(1));
        last_pos = (pos == frame_len - POS_W'(1));
    end

    // Frame state machine and line register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            pos  <= '0;
            sub  <= '0;
            txd  <= 1'b1;
        end else if (!busy) begin
            pos <= '0;
            sub <= '0;
            if (load) begin
                busy <= 1'b1;
                txd  <= 1'b0;
            end else begin
                txd  <= !brk_req;
            end
        end else if (slot_end) begin
            sub <= '0;
            if (last_pos) begin
                busy <= 1'b0;
                pos  <= '0;
                txd  <= !brk_req;
            end else begin
                pos  <= pos + POS_W'(1);
                txd  <= frame_bits[pos + POS_W'(1)];
            end
        end else if (tick) begin
            sub <= sub + SUB_W'(1);
        end
    end

    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!txd && busy && !in_ready));

    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load && !brk_req) |=> txd);

    a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && brk_req) |=> !txd);

    a_r6_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !slot_end) |=> $stable(txd));

    a_r7_sub_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sub < ticks_n));

    a_r3_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pos < frame_len));

endmodule

// File: rtl/uart_trim_tx.sv
// Top: serial character transmitter with per-bit timing trim. Wires the
// framer (capture), prescaler (sub-bit ticks) and sequencer (line control).
// Assumes the trim word covers 12 positions at two bits each.
module uart_trim_tx #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic [1:0]       cfg_len,
    input  logic             cfg_stop,
    input  logic [2:0]       cfg_par,
    input  logic [DIV_W-1:0] divisor,
    input  logic [23:0]      trim,
    input  logic             brk_req,
    output logic             txd,
    output logic             tx_empty
);
    import uart_trim_pkg::*;

    logic                 load;
    logic                 busy;
    logic                 tick;
    logic [FRAME_MAX-1:1] frame_bits;
    logic [POS_W-1:0]     frame_len;
    logic [TRIM_W-1:0]    trim_q;
    logic [DIV_W-1:0]     div_q;

    assign tx_empty = !busy;

    uart_trim_framer #(.DIV_W(DIV_W)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .in_data    (in_data),
        .cfg_len    (cfg_len),
        .cfg_stop   (cfg_stop),
        .cfg_par    (cfg_par),
        .divisor    (divisor),
        .trim       (trim),
        .frame_bits (frame_bits),
        .frame_len  (frame_len),
        .trim_q     (trim_q),
        .div_q      (div_q)
    );

    uart_trim_prescaler #(.DIV_W(DIV_W)) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .limit (div_q),
        .tick  (tick)
    );

    uart_trim_sequencer u_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .brk_req    (brk_req),
        .tick       (tick),
        .frame_bits (frame_bits),
        .frame_len  (frame_len),
        .trim_q     (trim_q),
        .in_ready   (in_ready),
        .load       (load),
        .busy       (busy),
        .txd        (txd)
    );

    a_r10_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tx_empty);

endmodule

// File: tb/uart_trim_tx_bench.sv
module uart_trim_tx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       in_data = '0;
    logic [1:0]       cfg_len = '0;
    logic             cfg_stop = 1'b0;
    logic [2:0]       cfg_par = '0;
    logic [DIV_W-1:0] divisor = '0;
    logic [23:0]      trim = '0;
    logic             brk_req = 1'b0;
    logic             txd;
    logic             tx_empty;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_trim_tx #(.DIV_W(DIV_W)) u_uart_trim_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .cfg_len(cfg_len), .cfg_stop(cfg_stop),
        .cfg_par(cfg_par), .divisor(divisor), .trim(trim),
        .brk_req(brk_req), .txd(txd), .tx_empty(tx_empty)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Expected frame bit at position k, from R3/R4/R5.
    function automatic int exp_frame(input logic [7:0] d, input int lc, input int st,
                                     input int pr, output bit b[12]);
        int nd = 5 + lc;
        int n;
        int ones = 0;
        b[0] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            b[1 + i] = d[i];
            ones += d[i];
        end
        n = 1 + nd;
        if (pr >= 4) begin
            case (pr)
                4: b[n] = (ones % 2 == 0);
                5: b[n] = (ones % 2 == 1);
                6: b[n] = 1'b1;
                default: b[n] = 1'b0;
            endcase
            n++;
        end
        b[n] = 1'b1; n++;
        if (st != 0) begin b[n] = 1'b1; n++; end
        return n;
    endfunction

    // Slot length in cycles, from R6/R7.
    function automatic int exp_slot(input int dv, input logic [23:0] tr, input int k);
        int code = int'(tr[2*k +: 2]);
        int m = (code == 1) ? 17 : (code == 3) ? 15 : 16;
        return (dv + 1) * m;
    endfunction

    // Send one frame and check the line cycle by cycle (R2-R8, R9, R10).
    task automatic run_frame(input logic [7:0] d, input int lc, input int st, input int pr,
                             input int dv, input logic [23:0] tr, input bit brk_mid,
                             input string tag);
        bit   b[12];
        int   n;
        int   c = 0;
        bit   ok = 1;
        int   bad_act = 0;
        int   bad_exp = 0;
        n = exp_frame(d, lc, st, pr, b);
        @(negedge clk);
        chk(in_ready === 1'b1, {tag, " R2 ready before offer"}, int'(in_ready), 1);
        in_data  = d;
        cfg_len  = 2'(lc);
        cfg_stop = 1'(st);
        cfg_par  = 3'(pr);
        divisor  = DIV_W'(dv);
        trim     = tr;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        // R8: scramble every setting once the byte is taken.
        in_data  = 8'($urandom);
        cfg_len  = 2'($urandom);
        cfg_stop = 1'($urandom);
        cfg_par  = 3'($urandom);
        divisor  = DIV_W'($urandom_range(0, 3));
        trim     = 24'($urandom);
        if (brk_mid) brk_req = 1'b1;
        for (int k = 0; k < n; k++) begin
            int len = exp_slot(dv, tr, k);
            for (int j = 0; j < len; j++) begin
                if (c != 0) @(negedge clk);
                if (ok && (txd !== b[k] || tx_empty !== 1'b0 || in_ready !== 1'b0)) begin
                    ok = 0;
                    bad_act = int'(txd) + 2 * int'(tx_empty) + 4 * int'(in_ready);
                    bad_exp = int'(b[k]);
                    $display("  mismatch at cycle %0d slot %0d", c, k);
                end
                c++;
            end
        end
        chk(ok, {tag, " R3 R4 R5 R6 R7 R8 frame waveform (txd+2*empty+4*ready)"},
            bad_act, bad_exp);
        @(negedge clk);
        chk(txd === !brk_mid, {tag, " R9 line after frame"}, int'(txd), int'(!brk_mid));
        chk(tx_empty === 1'b1, {tag, " R10 empty after frame"}, int'(tx_empty), 1);
        if (brk_mid) begin
            chk(in_ready === 1'b0, {tag, " R9 ready low during break"}, int'(in_ready), 0);
            brk_req = 1'b0;
            @(negedge clk);
            chk(txd === 1'b1, {tag, " R9 line high after break drop"}, int'(txd), 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1, "R1 reset txd", int'(txd), 1);
        chk(in_ready === 1'b1, "R1 reset ready", int'(in_ready), 1);
        chk(tx_empty === 1'b1, "R1 reset empty", int'(tx_empty), 1);

        run_frame(8'hA5, 3, 0, 0, 0, 24'h000000, 0, "8N1 nominal");
        run_frame(8'h1B, 0, 1, 4, 1, 24'h555555, 0, "5O2 all long");
        run_frame(8'h6C, 2, 0, 5, 0, 24'hFFFFFF, 0, "7E1 all short");
        run_frame(8'hFF, 3, 1, 6, 2, 24'hAAAAAA, 0, "8F1 code2 nop");
        run_frame(8'h00, 1, 0, 7, 0, 24'h9E4C71, 0, "6F0 mixed trim");
        run_frame(8'h3C, 0, 0, 0, 1, 24'hFFF000, 0, "5N1 unused trims");
        run_frame(8'h96, 3, 1, 5, 0, 24'h000001, 1, "break mid frame");

        // R9/R10: break raised while idle.
        @(negedge clk);
        brk_req = 1'b1;
        @(negedge clk);
        chk(txd === 1'b0, "R9 idle break line low", int'(txd), 0);
        chk(in_ready === 1'b0, "R9 idle break ready low", int'(in_ready), 0);
        chk(tx_empty === 1'b1, "R10 empty during idle break", int'(tx_empty), 1);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(tx_empty === 1'b1, "R2 no accept during break", int'(tx_empty), 1);
        brk_req = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1, "R1 line high after idle break", int'(txd), 1);

        for (int i = 0; i < 40; i++) begin
            run_frame(8'($urandom), int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
                      int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                      24'($urandom), ($urandom_range(0, 7) == 0), "random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule